// File: doc/BRIEF.md
# Selectable Event Interrupt Requester

This block turns one of four board events into a single interrupt request for the host. The four sources are an initialization-done pulse, a calibration-done pulse, a channels-ready status level and a buffer threshold level. A three-bit code in a control word picks the source. The buffer threshold can be watched for either its rising or its falling transition. Three codes are reserved and never request anything.

When the selected event occurs, a sticky request flag is set. The flag drives the interrupt output directly. The host reads the flag and the code through a register read port. It withdraws the request by writing the flag bit as zero. Every event input is registered once before its edges are detected. Changing the code therefore cannot produce a spurious request.

Top module: `evt_irq_req`

## Requirements
- R1: While reset is asserted, and right after it is released, the read word is all zeros and `irq_o` is low. This means the select code is 0 and the flag is clear.
- R2: In the control word, the select code sits at bits 10:8 and the request flag at bit 11. A write loads bits 10:8 into the code. Every other read bit is zero, whatever value was written to it.
- R3: Code 0 raises the request on a rising edge of `init_done_i`. Code 1 raises it on a rising edge of `cal_done_i`.
- R4: Code 2 raises the request on a rising edge of `chan_ready_i`. A level that stays high raises it only once.
- R5: Code 3 raises the request on a rising edge of `buf_thr_i`. Code 4 raises it on a falling edge of `buf_thr_i`.
- R6: Codes 5, 6 and 7 never raise the request, whatever the event inputs do.
- R7: The request flag stays set until a write puts 0 in bit 11. A write with 1 in bit 11 neither sets nor clears the flag.
- R8: If a write clears the flag in the same cycle that the selected event occurs, the flag stays set.
- R9: `irq_o` always equals the flag. An input edge that arrives before clock edge k shows on `irq_o` after clock edge k+1.
- R10: Edges on sources other than the selected one have no effect. An edge that falls in the same cycle as a write that changes the code is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done_i | input | 1 | Initialization-done event |
| cal_done_i | input | 1 | Calibration-done event |
| chan_ready_i | input | 1 | Channels-ready status level |
| buf_thr_i | input | 1 | Buffer threshold flag level |
| reg_wr_en | input | 1 | Control word write strobe |
| reg_wdata | input | REG_W | Control word write data |
| reg_rdata | output | REG_W | Control word read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 32-bit control word with the code at bit 8. At this size, every write can also drive ones into all of the unused bits, so the bench sees directly that those bits read back as zero. A three-bit code is small enough for the bench to sweep every value, including all three reserved codes, while toggling every input. Because the register path is only two stages deep, the bench can line up a write with the one cycle in which an event fires. It uses this to exercise the clear-collision case and the select-change case directly.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned N_SRC = 4;
  localparam int unsigned SRC_INIT = 0;
  localparam int unsigned SRC_CAL  = 1;
  localparam int unsigned SRC_RDY  = 2;
  localparam int unsigned SRC_THR  = 3;

  typedef enum logic [SEL_W-1:0] {
    EV_INIT     = 3'd0,
    EV_CAL      = 3'd1,
    EV_READY    = 3'd2,
    EV_THR_RISE = 3'd3,
    EV_THR_FALL = 3'd4
  } evt_code_e;
endpackage

// File: rtl/irq_edge_track.sv
module irq_edge_track #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] smp_q, prv_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic smp_d, prv_d;

    always_comb begin
      smp_d = din[i];
      prv_d = smp_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        smp_q[i] <= 1'b0;
        prv_q[i] <= 1'b0;
      end else begin
        smp_q[i] <= smp_d;
        prv_q[i] <= prv_d;
      end
    end

    assign rise[i] = smp_q[i] & ~prv_q[i];
    assign fall[i] = ~smp_q[i] & prv_q[i];
  end
endmodule

// File: rtl/irq_evt_select.sv
module irq_evt_select
  import irq_evt_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic [N_SRC-1:0] rise,
  input  logic [N_SRC-1:0] fall,
  input  logic             sel_chg,
  output logic             fire
);
  logic hit;

  always_comb begin
    case (sel)
      EV_INIT:     hit = rise[SRC_INIT];
      EV_CAL:      hit = rise[SRC_CAL];
      EV_READY:    hit = rise[SRC_RDY];
      EV_THR_RISE: hit = rise[SRC_THR];
      EV_THR_FALL: hit = fall[SRC_THR];
      default:     hit = 1'b0;
    endcase
    fire = hit & ~sel_chg;
  end
endmodule

// File: rtl/irq_req_reg.sv
module irq_req_reg
  import irq_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             wr_flag,
  input  logic             fire,
  output logic [SEL_W-1:0] sel_q,
  output logic             flag_q,
  output logic             sel_chg
);
  logic [SEL_W-1:0] sel_d;
  logic             flag_d;
  logic             sel_en;
  logic             flag_clr;

  always_comb begin
    sel_en   = wr_en;
    sel_chg  = wr_en && (wr_sel != sel_q);
    flag_clr = wr_en && !wr_flag;
    sel_d    = sel_en ? wr_sel : sel_q;
    flag_d   = fire | (flag_q & ~flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/evt_irq_req.sv
module evt_irq_req
  import irq_evt_pkg::*;
#(
  parameter int unsigned REG_W   = 32,
  parameter int unsigned SEL_LSB = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_done_i,
  input  logic             cal_done_i,
  input  logic             chan_ready_i,
  input  logic             buf_thr_i,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq_o
);
  localparam int unsigned FLAG_POS = SEL_LSB + SEL_W;

  logic [N_SRC-1:0] ev_in, rise, fall;
  logic [SEL_W-1:0] sel_q;
  logic             flag_q, sel_chg, fire;
  logic             unused_wbits;

  always_comb begin
    ev_in           = '0;
    ev_in[SRC_INIT] = init_done_i;
    ev_in[SRC_CAL]  = cal_done_i;
    ev_in[SRC_RDY]  = chan_ready_i;
    ev_in[SRC_THR]  = buf_thr_i;
  end

  irq_edge_track #(.N(N_SRC)) i_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ev_in),
    .rise (rise),
    .fall (fall)
  );

  irq_evt_select i_sel (
    .sel    (sel_q),
    .rise   (rise),
    .fall   (fall),
    .sel_chg(sel_chg),
    .fire   (fire)
  );

  irq_req_reg i_req (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr_en),
    .wr_sel (reg_wdata[SEL_LSB +: SEL_W]),
    .wr_flag(reg_wdata[FLAG_POS]),
    .fire   (fire),
    .sel_q  (sel_q),
    .flag_q (flag_q),
    .sel_chg(sel_chg)
  );

  assign unused_wbits = ^{reg_wdata[REG_W-1:FLAG_POS+1], reg_wdata[SEL_LSB-1:0]};

  always_comb begin
    reg_rdata                    = '0;
    reg_rdata[SEL_LSB +: SEL_W]  = sel_q;
    reg_rdata[FLAG_POS]          = flag_q;
  end

  assign irq_o = flag_q;
endmodule

// File: rtl/evt_irq_req_chk.sv
module evt_irq_req_chk
  import irq_evt_pkg::*;
#(
  parameter int unsigned REG_W   = 32,
  parameter int unsigned SEL_LSB = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_en,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             irq_o,
  input logic             fire
);
  localparam int unsigned FLAG_POS = SEL_LSB + SEL_W;

  // R9
  irq_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == reg_rdata[FLAG_POS]);

  // R6
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[SEL_LSB +: SEL_W] >= 3'd5 && !irq_o) |=> !irq_o);

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !(reg_wr_en && !reg_wdata[FLAG_POS])) |=> irq_o);

  // R8
  fire_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> irq_o);

  // R2
  sel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> reg_rdata[SEL_LSB +: SEL_W] == $past(reg_wdata[SEL_LSB +: SEL_W]));
endmodule

bind evt_irq_req evt_irq_req_chk #(.REG_W(REG_W), .SEL_LSB(SEL_LSB)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr_en(reg_wr_en),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .irq_o    (irq_o),
  .fire     (fire)
);

// File: tb/test_evt_irq_req.sv
module test_evt_irq_req;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        init_i, cal_i, rdy_i, thr_i;
  logic        wr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  evt_irq_req i_evt_irq_req (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_done_i (init_i),
    .cal_done_i  (cal_i),
    .chan_ready_i(rdy_i),
    .buf_thr_i   (thr_i),
    .reg_wr_en   (wr),
    .reg_wdata   (wdata),
    .reg_rdata   (rdata),
    .irq_o       (irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: queue of sampled input vectors {thr,rdy,cal,init}
  logic [3:0] hist[$];
  logic [2:0] m_sel;
  logic       m_flag;

  always @(posedge clk) begin
    logic [3:0] a, b;
    logic f;
    if (!rst_n) begin
      m_sel  = 3'd0;
      m_flag = 1'b0;
      hist   = {4'b0, 4'b0};
    end else begin
      a = hist[1];
      b = hist[0];
      case (m_sel)
        3'd0: f = a[0] & ~b[0];
        3'd1: f = a[1] & ~b[1];
        3'd2: f = a[2] & ~b[2];
        3'd3: f = a[3] & ~b[3];
        3'd4: f = ~a[3] & b[3];
        default: f = 1'b0;
      endcase
      if (wr && wdata[10:8] != m_sel) f = 1'b0;
      m_flag = f | (m_flag & ~(wr & ~wdata[11]));
      if (wr) m_sel = wdata[10:8];
      hist.push_back({thr_i, rdy_i, cal_i, init_i});
      void'(hist.pop_front());
    end
    #5;
    chk(irq === m_flag && rdata === {20'b0, m_flag, m_sel, 8'b0},
        "model R3 R4 R5 R6 R7 R9 R10", {irq, rdata[30:0]}, {m_flag, 20'b0, m_flag, m_sel, 8'b0});
  end

  task automatic wr_reg(input logic [2:0] s, input logic f);
    wr    = 1'b1;
    wdata = {20'hFFFFF, f, s, 8'hFF};
    @(negedge clk);
    wr    = 1'b0;
    wdata = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; init_i = 0; cal_i = 0; rdy_i = 0; thr_i = 0; wr = 0; wdata = '0;
    idle(3);
    chk(rdata == 32'h0 && irq == 1'b0, "R1 reset", {irq, rdata[30:0]}, 32'h0);
    rst_n = 1'b1;
    idle(2);
    chk(rdata == 32'h0 && irq == 1'b0, "R1 after release", {irq, rdata[30:0]}, 32'h0);

    // code 0, latency
    init_i = 1; @(negedge clk);
    init_i = 0;
    chk(irq == 1'b0, "R9 latency one edge", irq, 0);
    @(negedge clk);
    chk(irq == 1'b1, "R3 init edge", irq, 1);
    chk(rdata == 32'h0000_0800, "R2 flag at bit 11", rdata, 32'h0000_0800);
    idle(3);
    chk(irq == 1'b1, "R7 sticky", irq, 1);
    wr_reg(3'd0, 1'b1);
    chk(irq == 1'b1, "R7 write one keeps", irq, 1);
    wr_reg(3'd0, 1'b0);
    chk(irq == 1'b0, "R7 write zero clears", irq, 0);
    wr_reg(3'd0, 1'b1);
    chk(irq == 1'b0, "R7 write one no set", irq, 0);

    // code 1
    wr_reg(3'd1, 1'b0);
    chk(rdata == 32'h0000_0100, "R2 sel field, others zero", rdata, 32'h0000_0100);
    init_i = 1; @(negedge clk); init_i = 0; idle(2);
    chk(irq == 1'b0, "R10 other source ignored", irq, 0);
    cal_i = 1; @(negedge clk); cal_i = 0; @(negedge clk);
    chk(irq == 1'b1, "R3 cal edge", irq, 1);
    wr_reg(3'd1, 1'b0);

    // code 2
    wr_reg(3'd2, 1'b0);
    rdy_i = 1; idle(2);
    chk(irq == 1'b1, "R4 ready rise", irq, 1);
    wr_reg(3'd2, 1'b0);
    idle(4);
    chk(irq == 1'b0, "R4 level fires once", irq, 0);
    rdy_i = 0; idle(2);
    chk(irq == 1'b0, "R4 ready fall ignored", irq, 0);

    // codes 3 and 4
    wr_reg(3'd3, 1'b0);
    thr_i = 1; idle(2);
    chk(irq == 1'b1, "R5 thr rise", irq, 1);
    wr_reg(3'd3, 1'b0);
    thr_i = 0; idle(3);
    chk(irq == 1'b0, "R5 thr fall ignored on rise code", irq, 0);
    wr_reg(3'd4, 1'b0);
    thr_i = 1; idle(3);
    chk(irq == 1'b0, "R5 thr rise ignored on fall code", irq, 0);
    thr_i = 0; idle(2);
    chk(irq == 1'b1, "R5 thr fall", irq, 1);
    wr_reg(3'd4, 1'b0);

    // reserved codes
    for (int s = 5; s < 8; s++) begin
      wr_reg(s[2:0], 1'b0);
      chk(rdata[10:8] == s[2:0], "R2 sel readback", rdata, 32'(s) << 8);
      for (int k = 0; k < 4; k++) begin
        {thr_i, rdy_i, cal_i, init_i} = 4'hF; @(negedge clk);
        {thr_i, rdy_i, cal_i, init_i} = 4'h0; @(negedge clk);
      end
      idle(2);
      chk(irq == 1'b0, "R6 reserved quiet", irq, 0);
    end

    // clear collides with event
    wr_reg(3'd0, 1'b0);
    idle(2);
    init_i = 1; @(negedge clk);
    init_i = 0; wr = 1; wdata = 32'h0000_0000; @(negedge clk);
    wr = 0;
    chk(irq == 1'b1, "R8 clear loses to event", irq, 1);
    wr_reg(3'd0, 1'b0);
    chk(irq == 1'b0, "R7 clear after collision", irq, 0);

    // select change coincides with edge
    init_i = 1; cal_i = 1; @(negedge clk);
    init_i = 0; cal_i = 0; wr = 1; wdata = 32'h0000_0100; @(negedge clk);
    wr = 0; wdata = '0;
    chk(irq == 1'b0, "R10 edge dropped on sel change", irq, 0);
    idle(3);
    chk(irq == 1'b0, "R10 no late request", irq, 0);
    chk(rdata == 32'h0000_0100, "R2 code after change", rdata, 32'h0000_0100);

    idle(2);
    finish_run();
  end
endmodule